// File: doc/BRIEF.md
# LCD Horizontal Line Timing Generator

This block produces the horizontal timing of one raster line for an LCD panel interface. It advances only on a pixel-clock enable, and it takes four programmable counts as plain input ports. The counts are the leading wait, the number of pixels, the trailing wait and the width of the line-clock (hsync) pulse. Each count is given as its value minus one. While `run` is high the block repeats the line sequence without a break. A frame or vertical counter can follow the lines through the one-cycle `line_end` event.

The state machine has five named states. `LN_IDLE` holds while `run` is low. `LN_BEGIN` is the leading wait, `LN_PIXELS` is the data phase, `LN_END` is the trailing wait and `LN_SYNC` is the line-clock pulse. The transitions are:
- idle→begin when `run` is seen high. This move needs no enable.
- begin→pixels, pixels→end, end→sync and sync→begin, each taken on the enable at which the phase counter is zero.
- any state→idle at the first clock edge at which `run` is low.

On every line start the block latches the pixel count, the trailing wait, the sync width and the leading wait. A line start is either idle→begin or sync→begin. A count written in the middle of a line therefore applies from the next line.

Two display modes are supported. In passive mode the pixel clock output is present only during the data phase. In active mode it follows every enable whenever the block is running. A polarity input selects whether the line clock is asserted high or asserted low.

Top module: `lcd_line_timer`

## Requirements
- R1: While `run` is low, including after reset, the block is idle. In that state `pix_valid`, `pix_clk` and `line_end` are 0 and `line_clk` is at its inactive level. When `run` falls in mid-line, the block is idle after the next clock edge.
- R2: A line starts when `run` is seen in idle, or when a sync pulse ends. From that point, exactly `cfg_begin_wait`+1 enables pass before `pix_valid` rises. Leaving idle takes one clock with no enable needed.
- R3: `pix_valid` stays high for exactly `cfg_pix_per_line`+1 enables in each line. It is never high while the line clock is asserted.
- R4: After `pix_valid` falls, exactly `cfg_end_wait`+1 enables pass before the line clock asserts.
- R5: The line clock stays asserted for exactly `cfg_sync_width`+1 enables.
- R6: `cfg_sync_act_low`=0 makes the line clock active-high, and 1 makes it active-low. The inactive level is therefore equal to `cfg_sync_act_low`.
- R7: When `cfg_active_mode`=0 (passive), `pix_clk` pulses only on enables during the data phase. That gives exactly `cfg_pix_per_line`+1 pulses per line, and none in either wait or in the sync pulse.
- R8: When `cfg_active_mode`=1 (active), `pix_clk` equals `pix_ce` in every phase while running. A line then carries the sum of all four counts plus four pulses.
- R9: `line_end` is high for one clock. That clock is the first clock after the sync pulse ends, and no other clock of the line has it high.
- R10: The counts are captured at each line start. A change to the counts made during the data phase leaves the current line unchanged and takes effect on the following line.
- R11: Phases advance only on clocks with `pix_ce` high. `pix_clk` is never high without `pix_ce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables line generation; low forces idle |
| pix_ce | input | 1 | Pixel-clock enable; one pixel period per high cycle |
| cfg_begin_wait | input | BW (8) | Leading wait length minus one |
| cfg_pix_per_line | input | PW (10) | Pixels per line minus one |
| cfg_end_wait | input | EW (8) | Trailing wait length minus one |
| cfg_sync_width | input | SW (6) | Line-clock pulse width minus one |
| cfg_sync_act_low | input | 1 | 1 selects an active-low line clock |
| cfg_active_mode | input | 1 | 1 selects active (free-running pixel clock), 0 passive |
| line_clk | output | 1 | Line clock / hsync with selected polarity |
| pix_clk | output | 1 | Pixel clock pulse, gated by mode and phase |
| pix_valid | output | 1 | High during the data phase |
| line_end | output | 1 | One-clock event after each sync pulse |

## Verification
The bench uses the default widths of 8, 10, 8 and 6 bits. With these widths every count can be driven to its extreme. One vector sets a 256-enable wait on both sides, a 1024-pixel line and a 64-enable sync pulse, and another vector sets every phase to a single enable. Enable spacings of one, two and three clocks exercise the hold between enables. Each vector is run over two consecutive lines, so the sync→begin hand-over is checked as well as the start from idle.

// File: rtl/lcd_line_pkg.sv
`timescale 1ns/1ps
package lcd_line_pkg;

    typedef enum logic [2:0] {
        LN_IDLE   = 3'd0,
        LN_BEGIN  = 3'd1,
        LN_PIXELS = 3'd2,
        LN_END    = 3'd3,
        LN_SYNC   = 3'd4
    } ln_state_e;

    function automatic int wmax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lcd_line_shadow.sv
`timescale 1ns/1ps
// Holds the counts used after the leading wait, captured at each line start.
module lcd_line_shadow #(
    parameter int PW = 10,
    parameter int EW = 8,
    parameter int SW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [PW-1:0] in_pix,
    input  logic [EW-1:0] in_end,
    input  logic [SW-1:0] in_sync,
    output logic [PW-1:0] sh_pix,
    output logic [EW-1:0] sh_end,
    output logic [SW-1:0] sh_sync
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_pix  <= '0;
            sh_end  <= '0;
            sh_sync <= '0;
        end else if (load) begin
            sh_pix  <= in_pix;
            sh_end  <= in_end;
            sh_sync <= in_sync;
        end
    end

endmodule

// File: rtl/lcd_line_fsm.sv
`timescale 1ns/1ps
// Phase sequencer: one shared down counter, reloaded at each phase entry.
module lcd_line_fsm
    import lcd_line_pkg::*;
#(
    parameter int BW = 8,
    parameter int PW = 10,
    parameter int EW = 8,
    parameter int SW = 6,
    localparam int CW = wmax(wmax(BW, PW), wmax(EW, SW))
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          pix_ce,
    input  logic [BW-1:0] beg_wait,
    input  logic [PW-1:0] sh_pix,
    input  logic [EW-1:0] sh_end,
    input  logic [SW-1:0] sh_sync,
    output ln_state_e     st,
    output logic          load_fields,
    output logic          sync_done
);

    ln_state_e     st_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          cnt_zero;

    assign cnt_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= LN_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        st_n        = st;
        cnt_n       = cnt;
        load_fields = 1'b0;
        sync_done   = 1'b0;
        if (!run) begin
            st_n  = LN_IDLE;
            cnt_n = '0;
        end else begin
            unique case (st)
                LN_IDLE: begin
                    st_n        = LN_BEGIN;
                    cnt_n       = CW'(beg_wait);
                    load_fields = 1'b1;
                end
                LN_BEGIN: begin
                    if (pix_ce) begin
                        if (cnt_zero) begin
                            st_n  = LN_PIXELS;
                            cnt_n = CW'(sh_pix);
                        end else begin
                            cnt_n = cnt - CW'(1);
                        end
                    end
                end
                LN_PIXELS: begin
                    if (pix_ce) begin
                        if (cnt_zero) begin
                            st_n  = LN_END;
                            cnt_n = CW'(sh_end);
                        end else begin
                            cnt_n = cnt - CW'(1);
                        end
                    end
                end
                LN_END: begin
                    if (pix_ce) begin
                        if (cnt_zero) begin
                            st_n  = LN_SYNC;
                            cnt_n = CW'(sh_sync);
                        end else begin
                            cnt_n = cnt - CW'(1);
                        end
                    end
                end
                LN_SYNC: begin
                    if (pix_ce) begin
                        if (cnt_zero) begin
                            st_n        = LN_BEGIN;
                            cnt_n       = CW'(beg_wait);
                            load_fields = 1'b1;
                            sync_done   = 1'b1;
                        end else begin
                            cnt_n = cnt - CW'(1);
                        end
                    end
                end
                default: begin
                    st_n  = LN_IDLE;
                    cnt_n = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/lcd_line_outs.sv
`timescale 1ns/1ps
// Output decode: polarity, mode-dependent pixel clock gating, end event.
module lcd_line_outs
    import lcd_line_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  ln_state_e st,
    input  logic      pix_ce,
    input  logic      sync_done,
    input  logic      act_low,
    input  logic      active_mode,
    output logic      line_clk,
    output logic      pix_clk,
    output logic      pix_valid,
    output logic      line_end
);

    logic in_sync, in_data, running;

    always_comb begin
        in_sync   = (st == LN_SYNC);
        in_data   = (st == LN_PIXELS);
        running   = (st != LN_IDLE);
        line_clk  = in_sync ^ act_low;
        pix_valid = in_data;
        pix_clk   = pix_ce & (in_data | (active_mode & running));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) line_end <= 1'b0;
        else        line_end <= sync_done;
    end

endmodule

// File: rtl/lcd_line_timer.sv
`timescale 1ns/1ps
module lcd_line_timer
    import lcd_line_pkg::*;
#(
    parameter int BW = 8,
    parameter int PW = 10,
    parameter int EW = 8,
    parameter int SW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          pix_ce,
    input  logic [BW-1:0] cfg_begin_wait,
    input  logic [PW-1:0] cfg_pix_per_line,
    input  logic [EW-1:0] cfg_end_wait,
    input  logic [SW-1:0] cfg_sync_width,
    input  logic          cfg_sync_act_low,
    input  logic          cfg_active_mode,
    output logic          line_clk,
    output logic          pix_clk,
    output logic          pix_valid,
    output logic          line_end
);

    ln_state_e     ln_state;
    logic          load_fields;
    logic          sync_done;
    logic [PW-1:0] sh_pix;
    logic [EW-1:0] sh_end;
    logic [SW-1:0] sh_sync;

    lcd_line_shadow #(.PW(PW), .EW(EW), .SW(SW)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_fields),
        .in_pix  (cfg_pix_per_line),
        .in_end  (cfg_end_wait),
        .in_sync (cfg_sync_width),
        .sh_pix  (sh_pix),
        .sh_end  (sh_end),
        .sh_sync (sh_sync)
    );

    lcd_line_fsm #(.BW(BW), .PW(PW), .EW(EW), .SW(SW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .pix_ce      (pix_ce),
        .beg_wait    (cfg_begin_wait),
        .sh_pix      (sh_pix),
        .sh_end      (sh_end),
        .sh_sync     (sh_sync),
        .st          (ln_state),
        .load_fields (load_fields),
        .sync_done   (sync_done)
    );

    lcd_line_outs u_outs (
        .clk         (clk),
        .rst_n       (rst_n),
        .st          (ln_state),
        .pix_ce      (pix_ce),
        .sync_done   (sync_done),
        .act_low     (cfg_sync_act_low),
        .active_mode (cfg_active_mode),
        .line_clk    (line_clk),
        .pix_clk     (pix_clk),
        .pix_valid   (pix_valid),
        .line_end    (line_end)
    );

endmodule

// File: rtl/lcd_line_timer_chk.sv
`timescale 1ns/1ps
module lcd_line_timer_chk
    import lcd_line_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      run,
    input logic      pix_ce,
    input logic      cfg_sync_act_low,
    input logic      cfg_active_mode,
    input logic      line_clk,
    input logic      pix_clk,
    input logic      pix_valid,
    input logic      line_end,
    input ln_state_e st
);

    a_r1_idle_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st == LN_IDLE && !pix_valid && !pix_clk && line_clk == cfg_sync_act_low));

    a_r2_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LN_IDLE && run) |=> st == LN_BEGIN);

    a_r3_valid_not_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_valid && line_clk != cfg_sync_act_low));

    a_r7_passive_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_active_mode && !pix_valid) |-> !pix_clk);

    a_r8_active_free: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_active_mode && pix_ce && st != LN_IDLE) |-> pix_clk);

    a_r9_end_single: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> !line_end);

    a_r9_end_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |-> (st == LN_BEGIN && $past(st) == LN_SYNC));

    a_r11_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !pix_ce && st != LN_IDLE) |=> $stable(st));

    a_r11_no_clock_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_ce |-> !pix_clk);

endmodule

bind lcd_line_timer lcd_line_timer_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .run              (run),
    .pix_ce           (pix_ce),
    .cfg_sync_act_low (cfg_sync_act_low),
    .cfg_active_mode  (cfg_active_mode),
    .line_clk         (line_clk),
    .pix_clk          (pix_clk),
    .pix_valid        (pix_valid),
    .line_end         (line_end),
    .st               (ln_state)
);

// File: tb/sim_lcd_line_timer.sv
`timescale 1ns/1ps
module sim_lcd_line_timer;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, run, pix_ce;
    logic [7:0] c_bw, c_ew;
    logic [9:0] c_pw;
    logic [5:0] c_sw;
    logic       c_low, c_tft;
    logic       line_clk, pix_clk, pix_valid, line_end;

    int total = 0, bad = 0, cyc = 0, div = 1;
    int carry_en = 0, carry_pc = 0;
    bit finished = 1'b0;

    // {begin 8, pixels 10, end 8, sync 6, active 1, act_low 1, enable spacing 2}
    localparam logic [35:0] VEC [0:5] = '{
        {8'd0,   10'd0,    8'd0,   6'd0,  1'b0, 1'b0, 2'd1},
        {8'd3,   10'd7,    8'd2,   6'd1,  1'b0, 1'b1, 2'd2},
        {8'd5,   10'd15,   8'd4,   6'd3,  1'b1, 1'b0, 2'd3},
        {8'd1,   10'd2,    8'd7,   6'd5,  1'b1, 1'b1, 2'd1},
        {8'd255, 10'd1023, 8'd255, 6'd63, 1'b0, 1'b0, 2'd1},
        {8'd10,  10'd31,   8'd0,   6'd0,  1'b1, 1'b0, 2'd2}
    };

    lcd_line_timer u0 (
        .clk              (clk),
        .rst_n            (rst_n),
        .run              (run),
        .pix_ce           (pix_ce),
        .cfg_begin_wait   (c_bw),
        .cfg_pix_per_line (c_pw),
        .cfg_end_wait     (c_ew),
        .cfg_sync_width   (c_sw),
        .cfg_sync_act_low (c_low),
        .cfg_active_mode  (c_tft),
        .line_clk         (line_clk),
        .pix_clk          (pix_clk),
        .pix_valid        (pix_valid),
        .line_end         (line_end)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive pix_ce after the falling edge, then sample one ns later.
    task automatic step();
        @(negedge clk);
        cyc++;
        pix_ce = ((cyc % div) == 0);
        #1;
    endtask

    task automatic start_line();
        run = 1'b0;
        step();
        carry_en = 0;
        carry_pc = 0;
        run = 1'b1;
    endtask

    task automatic measure(input int e_bw, input int e_pv, input int e_ew, input int e_sy,
                           input bit chg, input int n_bw, input int n_pw, input string tag);
        int bw, pv, ew, sy, pc, ph, guard, ld, glitch, e_pc;
        bit la, ld_end, done;
        bw = carry_en; pc = carry_pc; pv = 0; ew = 0; sy = 0;
        ph = 0; guard = 0; ld = 0; glitch = 0; ld_end = 1'b0; done = 1'b0;
        while (!done && guard < 20000) begin
            step();
            guard++;
            la = (line_clk != c_low);
            if (ph == 0 && pix_valid) begin
                ph = 1;
                if (chg) begin
                    c_bw = 8'(n_bw);
                    c_pw = 10'(n_pw);
                end
            end else if (ph == 1 && !pix_valid) begin
                ph = 2;
            end
            if (ph == 2 && la) begin
                ph = 3;
            end else if (ph == 3 && !la) begin
                ld_end   = line_end;
                carry_en = pix_ce ? 1 : 0;
                carry_pc = pix_clk ? 1 : 0;
                done     = 1'b1;
            end
            if (!done) begin
                if (pix_clk && !pix_ce) glitch++;
                if (pix_valid && la) glitch++;
                if (line_end) ld++;
                if (pix_ce) begin
                    case (ph)
                        0:       bw++;
                        1:       pv++;
                        2:       ew++;
                        default: sy++;
                    endcase
                end
                if (pix_clk) pc++;
            end
        end
        e_pc = c_tft ? (e_bw + e_pv + e_ew + e_sy) : e_pv;
        chk("R2", {tag, " begin wait enables"}, bw, e_bw);
        chk("R3", {tag, " valid enables (R11 spacing)"}, pv, e_pv);
        chk("R4", {tag, " end wait enables"}, ew, e_ew);
        chk("R5", {tag, " sync enables"}, sy, e_sy);
        chk("R9", {tag, " line_end at sync end"}, ld_end ? 1 : 0, 1);
        chk("R9", {tag, " line_end elsewhere"}, ld, 0);
        chk(c_tft ? "R8" : "R7", {tag, " pix_clk pulses"}, pc, e_pc);
        chk("R11", {tag, " pix_clk w/o enable or valid in sync"}, glitch, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [35:0] v;
        rst_n = 1'b0; run = 1'b0; pix_ce = 1'b1;
        c_bw = 8'd2; c_pw = 10'd3; c_ew = 8'd1; c_sw = 6'd0;
        c_low = 1'b1; c_tft = 1'b1; div = 1;

        // Reset and idle state (R1, R6)
        repeat (3) step();
        chk("R1", "pix_valid in reset", int'(pix_valid), 0);
        chk("R6", "line_clk idle level act-low", int'(line_clk), 1);
        rst_n = 1'b1;
        repeat (3) step();
        chk("R1", "pix_clk idle active mode", int'(pix_clk), 0);
        chk("R1", "line_end idle", int'(line_end), 0);
        c_low = 1'b0;
        step();
        chk("R6", "line_clk idle level act-high", int'(line_clk), 0);

        // Table of vectors, two lines each
        for (int i = 0; i < 6; i++) begin
            v = VEC[i];
            run   = 1'b0;
            c_bw  = v[35:28];
            c_pw  = v[27:18];
            c_ew  = v[17:10];
            c_sw  = v[9:4];
            c_tft = v[3];
            c_low = v[2];
            div   = int'(v[1:0]);
            start_line();
            measure(int'(c_bw) + 1, int'(c_pw) + 1, int'(c_ew) + 1, int'(c_sw) + 1,
                    1'b0, 0, 0, $sformatf("vec%0d line1", i));
            measure(int'(c_bw) + 1, int'(c_pw) + 1, int'(c_ew) + 1, int'(c_sw) + 1,
                    1'b0, 0, 0, $sformatf("vec%0d line2", i));
        end

        // R10: counts changed mid-line apply from the next line
        div = 1; c_tft = 1'b0; c_low = 1'b0;
        c_bw = 8'd2; c_pw = 10'd3; c_ew = 8'd1; c_sw = 6'd0;
        start_line();
        measure(3, 4, 2, 1, 1'b1, 6, 7, "R10 current line");
        measure(7, 8, 2, 1, 1'b0, 0, 0, "R10 next line");

        // R1: run dropped during the data phase
        c_tft = 1'b1; c_low = 1'b1;
        c_bw = 8'd1; c_pw = 10'd9; c_ew = 8'd1; c_sw = 6'd1;
        start_line();
        repeat (4) step();
        chk("R1", "in data phase before stop", int'(pix_valid), 1);
        run = 1'b0;
        step();
        chk("R1", "pix_valid after stop", int'(pix_valid), 0);
        chk("R1", "pix_clk after stop", int'(pix_clk), 0);
        chk("R1", "line_clk inactive after stop", int'(line_clk), 1);
        start_line();
        measure(2, 10, 2, 2, 1'b0, 0, 0, "R1 restart");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule